// File: doc/BRIEF.md
# Cache Parity Guard

This block sits beside a cache's tag and data RAMs and protects them with parity. On the write path it produces the check bits that are stored with a line. Each byte of a data word gets one bit. The tag entry gets one bit, and that bit also covers the line's dirty flag. On the read path it recomputes those bits, compares them with the stored copy and decides how the cache must react to a mismatch. A static input selects odd or even parity for both paths.

Recovery has two actions, and each cache side (instruction or data) enables them separately. The hardware action asks the cache controller to invalidate the faulting line and replay the access, so that the access misses and refetches clean data. The software action raises a precise abort. Either action can be enabled alone, both can run together, and with neither enabled the side is not checked. A mismatch on a dirty line cannot be repaired by invalidation, so the block raises an abort and marks the error unrecoverable. A status record captures the side, set, way, failing bytes, tag flag and address of the first error. Later errors set only a sticky overflow flag, until software clears the record.

Top module: `cpar_guard`

## Requirements
- R1: `wr_data_par[b]` is the parity of data byte b (bits 8b+7..8b), computed for the mode set by `cfg_odd`. With `cfg_odd`=1 the byte plus its bit hold an odd number of ones. With `cfg_odd`=0 they hold an even number.
- R2: `wr_tag_par` is a single bit computed the same way over the tag together with the dirty flag.
- R3: A read with `rd_valid`=1 on a checked side is in error when any byte's stored bit differs from the recomputed one, or when the tag bit differs. The differing bytes are recorded as a mask in `fsr_byte_err` (bit b = byte b), and a tag difference sets `fsr_tag_err`.
- R4: When both enables of the accessed side are 0, a read produces no request pulses and leaves the status record unchanged.
- R5: An error on a clean line, with the side's hardware enable set, pulses `inval_req` and `replay_req` together on the cycle after the read. `inval_set` and `inval_way` then carry the read's set and way.
- R6: An error with the side's software enable set pulses `abort_req` on the cycle after the read.
- R7: With both enables set, a clean-line error produces the invalidate, replay and abort pulses in the same cycle.
- R8: `rd_side` (0 = instruction, 1 = data) selects which pair of enables applies. The other side's enables have no effect on that read.
- R9: An error on a line read with `rd_dirty`=1 never requests invalidate or replay. It always raises `abort_req`, whatever the enables of the checked side, and the captured record has `fsr_unrec`=1.
- R10: The first error captures side, set, way, byte mask, tag flag, unrecoverable flag and `far_addr`, and sets `fsr_valid`. Any error while `fsr_valid`=1 leaves those fields unchanged and sets `fsr_overflow`, which stays set.
- R11: `st_clr` clears `fsr_valid` and `fsr_overflow` at the next edge. An error in that same cycle is captured as a fresh first error, with overflow 0.
- R12: `force_wt` equals the data side's hardware enable, so that the data cache is held write-through while hardware recovery is on.
- R13: Request outputs are single-cycle pulses. A read with matching parity, or a cycle with no read, leaves them low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even parity |
| i_hw_fix_en | input | 1 | Instruction side: invalidate and replay on error |
| i_sw_abort_en | input | 1 | Instruction side: abort on error |
| d_hw_fix_en | input | 1 | Data side: invalidate and replay on error |
| d_sw_abort_en | input | 1 | Data side: abort on error |
| force_wt | output | 1 | Hold the data cache write-through |
| wr_data | input | DATA_W | Data word being written |
| wr_tag | input | TAG_W | Tag being written |
| wr_dirty | input | 1 | Dirty flag being written |
| wr_data_par | output | DATA_W/8 | Per-byte parity to store |
| wr_tag_par | output | 1 | Tag and dirty parity to store |
| rd_valid | input | 1 | A read is presented this cycle |
| rd_side | input | 1 | 0 = instruction, 1 = data |
| rd_addr | input | ADDR_W | Address of the access |
| rd_set | input | SET_W | Set index of the read line |
| rd_way | input | WAY_W | Way of the read line |
| rd_data | input | DATA_W | Data word read from RAM |
| rd_data_par | input | DATA_W/8 | Stored per-byte parity |
| rd_tag | input | TAG_W | Tag read from RAM |
| rd_dirty | input | 1 | Dirty flag read from RAM |
| rd_tag_par | input | 1 | Stored tag parity |
| st_clr | input | 1 | Clear the status record |
| inval_req | output | 1 | Invalidate the faulting line |
| replay_req | output | 1 | Replay the faulting access |
| inval_set | output | SET_W | Set to invalidate |
| inval_way | output | WAY_W | Way to invalidate |
| abort_req | output | 1 | Precise abort request |
| fsr_valid | output | 1 | Status record holds an error |
| fsr_overflow | output | 1 | A later error arrived while the record was held |
| fsr_side | output | 1 | Side of the recorded error |
| fsr_set | output | SET_W | Set of the recorded error |
| fsr_way | output | WAY_W | Way of the recorded error |
| fsr_byte_err | output | DATA_W/8 | Mask of failing data bytes |
| fsr_tag_err | output | 1 | Tag parity failed |
| fsr_unrec | output | 1 | Error hit a dirty line |
| far_addr | output | ADDR_W | Address of the recorded error |

## Verification
The bench corrupts single bytes, several bytes at once, the top byte and the tag bit, under odd and even parity. A design that swapped byte lanes or dropped the dirty flag from tag parity would then report the wrong mask or miss the error. It opens one side's enables while the other side's are closed, which exposes any crossed enable. It also makes errors on dirty lines with only the hardware action enabled, where a careless design would invalidate modified data without telling software. Back-to-back errors and a clear that lands in the same cycle as a new error show whether the first record gets overwritten or the overflow flag is lost.

// File: rtl/cpar_pkg.sv
package cpar_pkg;

  typedef enum logic {SIDE_INSTR = 1'b0, SIDE_DATA = 1'b1} side_e;

  // widest field folded into one parity bit
  localparam int FOLD_W = 64;

  // check bit for a field: XOR of its bits, inverted for odd parity
  function automatic logic par_fold(input logic [FOLD_W-1:0] v, input logic odd);
    return (^v) ^ odd;
  endfunction

endpackage

// File: rtl/cpar_gen.sv
module cpar_gen
  import cpar_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 20,
  localparam int NBYTE = DATA_W / 8
) (
  input  logic             odd,
  input  logic [DATA_W-1:0] data,
  input  logic [TAG_W-1:0]  tag,
  input  logic             dirty,
  output logic [NBYTE-1:0] data_par,
  output logic             tag_par
);

  // one check bit per byte lane
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign data_par[b] = par_fold(FOLD_W'(data[8*b +: 8]), odd);
  end

  // tag entry bit covers the dirty flag as well
  assign tag_par = par_fold(FOLD_W'({dirty, tag}), odd);

endmodule

// File: rtl/cpar_cmp.sv
module cpar_cmp #(
  parameter int NBYTE = 8
) (
  input  logic [NBYTE-1:0] calc_data_par,
  input  logic [NBYTE-1:0] stored_data_par,
  input  logic             calc_tag_par,
  input  logic             stored_tag_par,
  output logic [NBYTE-1:0] byte_mism,
  output logic             tag_mism
);

  for (genvar b = 0; b < NBYTE; b++) begin : g_cmp
    assign byte_mism[b] = calc_data_par[b] != stored_data_par[b];
  end

  assign tag_mism = calc_tag_par != stored_tag_par;

endmodule

// File: rtl/cpar_policy.sv
module cpar_policy #(
  parameter int NBYTE  = 8,
  parameter int SET_W  = 7,
  parameter int WAY_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              side,
  input  logic              hw_en,
  input  logic              sw_en,
  input  logic              dirty,
  input  logic [SET_W-1:0]  set,
  input  logic [WAY_W-1:0]  way,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTE-1:0]  byte_mism,
  input  logic              tag_mism,
  input  logic              st_clr,
  output logic              inval_req,
  output logic              replay_req,
  output logic [SET_W-1:0]  inval_set,
  output logic [WAY_W-1:0]  inval_way,
  output logic              abort_req,
  output logic              fsr_valid,
  output logic              fsr_overflow,
  output logic              fsr_side,
  output logic [SET_W-1:0]  fsr_set,
  output logic [WAY_W-1:0]  fsr_way,
  output logic [NBYTE-1:0]  fsr_byte_err,
  output logic              fsr_tag_err,
  output logic              fsr_unrec,
  output logic [ADDR_W-1:0] far_addr
);

  // named events for the checks below
  logic chk_on, evt_err, evt_fix, evt_notify, rec_held;

  assign chk_on     = hw_en | sw_en;
  assign evt_err    = rd_valid & chk_on & ((|byte_mism) | tag_mism);
  assign evt_fix    = evt_err & hw_en & ~dirty;
  assign evt_notify = evt_err & (sw_en | dirty);
  assign rec_held   = fsr_valid & ~st_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inval_req  <= 1'b0;
      replay_req <= 1'b0;
      abort_req  <= 1'b0;
      inval_set  <= '0;
      inval_way  <= '0;
    end else begin
      inval_req  <= evt_fix;
      replay_req <= evt_fix;
      abort_req  <= evt_notify;
      if (evt_fix) begin
        inval_set <= set;
        inval_way <= way;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_valid    <= 1'b0;
      fsr_overflow <= 1'b0;
      fsr_side     <= 1'b0;
      fsr_set      <= '0;
      fsr_way      <= '0;
      fsr_byte_err <= '0;
      fsr_tag_err  <= 1'b0;
      fsr_unrec    <= 1'b0;
      far_addr     <= '0;
    end else begin
      if (st_clr) begin
        fsr_valid    <= 1'b0;
        fsr_overflow <= 1'b0;
        fsr_byte_err <= '0;
        fsr_tag_err  <= 1'b0;
        fsr_unrec    <= 1'b0;
      end
      if (evt_err) begin
        if (!rec_held) begin
          fsr_valid    <= 1'b1;
          fsr_side     <= side;
          fsr_set      <= set;
          fsr_way      <= way;
          fsr_byte_err <= byte_mism;
          fsr_tag_err  <= tag_mism;
          fsr_unrec    <= dirty;
          far_addr     <= addr;
        end else begin
          fsr_overflow <= 1'b1;
        end
      end
    end
  end

  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !hw_en && !sw_en) |=> (!inval_req && !abort_req));

  assert_fix_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_err && hw_en && !dirty) |=> (inval_req && replay_req &&
                                      inval_set == $past(set) && inval_way == $past(way)));

  assert_abort_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_err && sw_en) |=> abort_req);

  assert_dirty_no_inval_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_err && dirty) |=> (!inval_req && !replay_req && abort_req));

  assert_first_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_held |=> (fsr_valid && $stable(far_addr) && $stable(fsr_set) && $stable(fsr_way)));

  assert_no_overflow_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_overflow && !st_clr) |=> fsr_overflow);

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr && !evt_err) |=> (!fsr_valid && !fsr_overflow));

  assert_quiet_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (!inval_req && !replay_req && !abort_req));

endmodule

// File: rtl/cpar_guard.sv
module cpar_guard
  import cpar_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 20,
  parameter int SET_W  = 7,
  parameter int WAY_W  = 2,
  parameter int ADDR_W = 32,
  localparam int NBYTE = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_odd,
  input  logic              i_hw_fix_en,
  input  logic              i_sw_abort_en,
  input  logic              d_hw_fix_en,
  input  logic              d_sw_abort_en,
  output logic              force_wt,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_dirty,
  output logic [NBYTE-1:0]  wr_data_par,
  output logic              wr_tag_par,
  input  logic              rd_valid,
  input  logic              rd_side,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [NBYTE-1:0]  rd_data_par,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              rd_dirty,
  input  logic              rd_tag_par,
  input  logic              st_clr,
  output logic              inval_req,
  output logic              replay_req,
  output logic [SET_W-1:0]  inval_set,
  output logic [WAY_W-1:0]  inval_way,
  output logic              abort_req,
  output logic              fsr_valid,
  output logic              fsr_overflow,
  output logic              fsr_side,
  output logic [SET_W-1:0]  fsr_set,
  output logic [WAY_W-1:0]  fsr_way,
  output logic [NBYTE-1:0]  fsr_byte_err,
  output logic              fsr_tag_err,
  output logic              fsr_unrec,
  output logic [ADDR_W-1:0] far_addr
);

  logic [NBYTE-1:0] calc_data_par, byte_mism;
  logic             calc_tag_par, tag_mism;
  logic             sel_hw, sel_sw;

  // enables of the side being read
  assign sel_hw   = (rd_side == SIDE_DATA) ? d_hw_fix_en   : i_hw_fix_en;
  assign sel_sw   = (rd_side == SIDE_DATA) ? d_sw_abort_en : i_sw_abort_en;
  assign force_wt = d_hw_fix_en;

  cpar_gen #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_wr_gen (
    .odd(cfg_odd), .data(wr_data), .tag(wr_tag), .dirty(wr_dirty),
    .data_par(wr_data_par), .tag_par(wr_tag_par)
  );

  cpar_gen #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd_gen (
    .odd(cfg_odd), .data(rd_data), .tag(rd_tag), .dirty(rd_dirty),
    .data_par(calc_data_par), .tag_par(calc_tag_par)
  );

  cpar_cmp #(.NBYTE(NBYTE)) u_cmp (
    .calc_data_par(calc_data_par), .stored_data_par(rd_data_par),
    .calc_tag_par(calc_tag_par), .stored_tag_par(rd_tag_par),
    .byte_mism(byte_mism), .tag_mism(tag_mism)
  );

  cpar_policy #(.NBYTE(NBYTE), .SET_W(SET_W), .WAY_W(WAY_W), .ADDR_W(ADDR_W)) u_policy (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .side(rd_side),
    .hw_en(sel_hw), .sw_en(sel_sw), .dirty(rd_dirty),
    .set(rd_set), .way(rd_way), .addr(rd_addr),
    .byte_mism(byte_mism), .tag_mism(tag_mism), .st_clr(st_clr),
    .inval_req(inval_req), .replay_req(replay_req),
    .inval_set(inval_set), .inval_way(inval_way), .abort_req(abort_req),
    .fsr_valid(fsr_valid), .fsr_overflow(fsr_overflow), .fsr_side(fsr_side),
    .fsr_set(fsr_set), .fsr_way(fsr_way), .fsr_byte_err(fsr_byte_err),
    .fsr_tag_err(fsr_tag_err), .fsr_unrec(fsr_unrec), .far_addr(far_addr)
  );

  // the write side must never hand a dirty line to the cache while hardware recovery is on
  assert_wt_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_side && d_hw_fix_en) |-> force_wt);

endmodule

// File: tb/cpar_guard_test.sv
module cpar_guard_test;

  localparam int DW = 64;
  localparam int TW = 20;
  localparam int SW = 7;
  localparam int WW = 2;
  localparam int AW = 32;
  localparam int NB = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_odd = 1'b0;
  logic i_hw = 1'b0, i_sw = 1'b0, d_hw = 1'b0, d_sw = 1'b0;
  logic force_wt;
  logic [DW-1:0] wr_data = '0;
  logic [TW-1:0] wr_tag = '0;
  logic wr_dirty = 1'b0;
  logic [NB-1:0] wr_data_par;
  logic wr_tag_par;
  logic rd_valid = 1'b0, rd_side = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [SW-1:0] rd_set = '0;
  logic [WW-1:0] rd_way = '0;
  logic [DW-1:0] rd_data = '0;
  logic [NB-1:0] rd_data_par = '0;
  logic [TW-1:0] rd_tag = '0;
  logic rd_dirty = 1'b0, rd_tag_par = 1'b0, st_clr = 1'b0;
  logic inval_req, replay_req, abort_req;
  logic [SW-1:0] inval_set, fsr_set;
  logic [WW-1:0] inval_way, fsr_way;
  logic fsr_valid, fsr_overflow, fsr_side, fsr_tag_err, fsr_unrec;
  logic [NB-1:0] fsr_byte_err;
  logic [AW-1:0] far_addr;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpar_guard #(.DATA_W(DW), .TAG_W(TW), .SET_W(SW), .WAY_W(WW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_odd(cfg_odd),
    .i_hw_fix_en(i_hw), .i_sw_abort_en(i_sw), .d_hw_fix_en(d_hw), .d_sw_abort_en(d_sw),
    .force_wt(force_wt), .wr_data(wr_data), .wr_tag(wr_tag), .wr_dirty(wr_dirty),
    .wr_data_par(wr_data_par), .wr_tag_par(wr_tag_par),
    .rd_valid(rd_valid), .rd_side(rd_side), .rd_addr(rd_addr), .rd_set(rd_set),
    .rd_way(rd_way), .rd_data(rd_data), .rd_data_par(rd_data_par), .rd_tag(rd_tag),
    .rd_dirty(rd_dirty), .rd_tag_par(rd_tag_par), .st_clr(st_clr),
    .inval_req(inval_req), .replay_req(replay_req), .inval_set(inval_set),
    .inval_way(inval_way), .abort_req(abort_req), .fsr_valid(fsr_valid),
    .fsr_overflow(fsr_overflow), .fsr_side(fsr_side), .fsr_set(fsr_set),
    .fsr_way(fsr_way), .fsr_byte_err(fsr_byte_err), .fsr_tag_err(fsr_tag_err),
    .fsr_unrec(fsr_unrec), .far_addr(far_addr)
  );

  // vector: side hw sw dirty tagflip | byte flip mask[7:0] | exp inval, exp abort, exp unrec
  localparam int NVEC = 11;
  localparam logic [15:0] VEC [NVEC] = '{
    16'b1_1_0_0_0_00000001_1_0_0,
    16'b1_0_1_0_0_00000100_0_1_0,
    16'b1_1_1_0_1_00000000_1_1_0,
    16'b0_1_0_0_0_10000000_1_0_0,
    16'b0_0_1_0_1_00000000_0_1_0,
    16'b1_0_0_0_0_11111111_0_0_0,
    16'b0_0_0_0_0_00000001_0_0_0,
    16'b1_0_1_1_0_00000001_0_1_1,
    16'b1_1_0_1_1_00000000_0_1_1,
    16'b1_1_1_0_0_00000000_0_0_0,
    16'b1_1_1_1_0_00110000_0_1_1
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent parity model: count ones per lane
  function automatic logic [NB-1:0] model_data_par(input logic [DW-1:0] d, input logic odd);
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) begin
      if ($countones(d[8*b +: 8]) % 2 == 1) r[b] = odd ? 1'b0 : 1'b1;
      else                                  r[b] = odd ? 1'b1 : 1'b0;
    end
    return r;
  endfunction

  function automatic logic model_tag_par(input logic [TW-1:0] t, input logic dty, input logic odd);
    int n;
    n = $countones(t) + (dty ? 1 : 0);
    return (n % 2 == 1) ? ~odd : odd;
  endfunction

  // present one read whose stored bits come from the write path, then flip some
  task automatic do_read(input logic side, input logic [DW-1:0] d, input logic [TW-1:0] t,
                         input logic dty, input int set, input int way, input logic [AW-1:0] a,
                         input logic [NB-1:0] mask, input logic tf);
    wr_data = d; wr_tag = t; wr_dirty = dty;
    #1;
    rd_side = side; rd_data = d; rd_tag = t; rd_dirty = dty;
    rd_data_par = wr_data_par ^ mask; rd_tag_par = wr_tag_par ^ tf;
    rd_set = SW'(set); rd_way = WW'(way); rd_addr = a; rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic clear_status();
    st_clr = 1'b1;
    @(negedge clk);
    st_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!inval_req && !replay_req && !abort_req, "R13", "reset requests",
          {inval_req, replay_req, abort_req}, 0);
    check(!fsr_valid && !fsr_overflow, "R10", "reset status", {fsr_valid, fsr_overflow}, 0);

    // R1 / R2: write-path parity, both modes
    for (int k = 0; k < 4; k++) begin
      logic [DW-1:0] d;
      d = (k == 0) ? 64'h0 : (k == 1) ? 64'h0103_0700_FF01_8001 :
          (k == 2) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h8421_1248_DEAD_BEEF;
      for (int m = 0; m < 2; m++) begin
        cfg_odd = m[0];
        wr_data = d; wr_tag = TW'(k * 20'h1357B); wr_dirty = k[0];
        #1;
        check(wr_data_par == model_data_par(d, m[0]), "R1", "data parity",
              64'(wr_data_par), 64'(model_data_par(d, m[0])));
        check(wr_tag_par == model_tag_par(wr_tag, wr_dirty, m[0]), "R2", "tag parity",
              64'(wr_tag_par), 64'(model_tag_par(wr_tag, wr_dirty, m[0])));
      end
    end
    @(negedge clk);

    // table walk: R3..R9
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      logic sd, hw, sw, dty, tf, e_inv, e_abt, e_unr, e_err;
      logic [NB-1:0] mask;
      logic [AW-1:0] a;
      v = VEC[i];
      sd = v[15]; hw = v[14]; sw = v[13]; dty = v[12]; tf = v[11];
      mask = v[10:3]; e_inv = v[2]; e_abt = v[1]; e_unr = v[0];
      e_err = ((mask != 0) || tf) && (hw || sw);
      a = 32'h0000_1000 + 32'(i * 64);
      cfg_odd = i[0];
      // the side not being read gets the opposite enables (R8)
      if (sd) begin d_hw = hw; d_sw = sw; i_hw = ~hw; i_sw = ~sw; end
      else    begin i_hw = hw; i_sw = sw; d_hw = ~hw; d_sw = ~sw; end
      clear_status();
      do_read(sd, 64'h0123_4567_89AB_CDEF ^ DW'(i * 32'h0101_0F0F), TW'(20'hA5A5A + i), dty,
              i + 5, i % 4, a, mask, tf);
      check(inval_req == e_inv && replay_req == e_inv, "R5", $sformatf("vec %0d invalidate/replay", i),
            {inval_req, replay_req}, {e_inv, e_inv});
      check(abort_req == e_abt, "R6", $sformatf("vec %0d abort", i), 64'(abort_req), 64'(e_abt));
      check(fsr_valid == e_err, "R4", $sformatf("vec %0d record valid (R8 side select)", i),
            64'(fsr_valid), 64'(e_err));
      if (e_inv)
        check(inval_set == SW'(i + 5) && inval_way == WW'(i % 4), "R5", "invalidate target",
              {inval_set, inval_way}, {SW'(i + 5), WW'(i % 4)});
      if (e_err) begin
        check(fsr_byte_err == mask && fsr_tag_err == tf, "R3", $sformatf("vec %0d fault mask", i),
              {fsr_byte_err, fsr_tag_err}, {mask, tf});
        check(fsr_unrec == e_unr, "R9", $sformatf("vec %0d unrecoverable", i),
              64'(fsr_unrec), 64'(e_unr));
        check(far_addr == a && fsr_side == sd && fsr_set == SW'(i + 5), "R10", "record fields",
              {far_addr, fsr_side, fsr_set}, {a, sd, SW'(i + 5)});
      end
      if (e_inv && e_abt)
        check(inval_req && abort_req, "R7", "both actions together", {inval_req, abort_req}, 2'b11);
      @(negedge clk);
      check(!inval_req && !replay_req && !abort_req, "R13", "pulse ends",
            {inval_req, replay_req, abort_req}, 0);
    end

    // R12: write-through hold follows data-side hardware enable
    d_hw = 1'b1; #1;
    check(force_wt == 1'b1, "R12", "force_wt on", 64'(force_wt), 1);
    d_hw = 1'b0; #1;
    check(force_wt == 1'b0, "R12", "force_wt off", 64'(force_wt), 0);

    // R10: second error keeps the first record and sets overflow
    i_hw = 0; i_sw = 0; d_hw = 0; d_sw = 1; cfg_odd = 1'b0;
    clear_status();
    do_read(1'b1, 64'h55, 20'h1, 1'b0, 3, 1, 32'hAAAA_0000, 8'h02, 1'b0);
    do_read(1'b1, 64'h77, 20'h2, 1'b0, 9, 2, 32'hBBBB_0000, 8'h00, 1'b1);
    check(abort_req == 1'b1, "R6", "second abort", 64'(abort_req), 1);
    check(far_addr == 32'hAAAA_0000 && fsr_set == SW'(3) && fsr_byte_err == 8'h02,
          "R10", "first error kept", {far_addr, fsr_set}, {32'hAAAA_0000, SW'(3)});
    check(fsr_overflow == 1'b1, "R10", "overflow set", 64'(fsr_overflow), 1);
    do_read(1'b1, 64'h99, 20'h3, 1'b0, 4, 0, 32'hCCCC_0000, 8'h00, 1'b0);
    check(fsr_overflow == 1'b1 && !abort_req, "R13", "clean read, overflow sticky",
          {fsr_overflow, abort_req}, 2'b10);

    // R11: clear alone, then clear together with a new error
    clear_status();
    check(!fsr_valid && !fsr_overflow, "R11", "clear", {fsr_valid, fsr_overflow}, 0);
    do_read(1'b1, 64'h11, 20'h4, 1'b0, 6, 3, 32'hDDDD_0000, 8'h01, 1'b0);
    st_clr = 1'b1;
    do_read(1'b1, 64'h22, 20'h5, 1'b0, 7, 1, 32'hEEEE_0000, 8'h40, 1'b0);
    st_clr = 1'b0;
    check(fsr_valid && !fsr_overflow && far_addr == 32'hEEEE_0000 && fsr_byte_err == 8'h40,
          "R11", "clear with new error", {fsr_valid, fsr_overflow, far_addr},
          {1'b1, 1'b0, 32'hEEEE_0000});

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R13 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule